// File: doc/BRIEF.md
# Configurable CRC and Checksum Engine

This block computes a running integrity value over a stream of 32-bit data beats. One datapath provides four CRC polynomials and a 16-bit ones'-complement sum of the kind used by internet transport headers. A 32-bit control word chooses the algorithm and the input shaping: byte-lane reordering, item width and input bit reflection. The same word chooses the output shaping: output bit reflection and complement. It also chooses where the register starts after a restart. A separate 32-bit seed word supplies the start value when the control word asks for it.

The host drives the control and seed words, pulses `restart` to load the start value, then streams beats on a valid/ready handshake. The engine takes one beat per clock. `result` is a combinational view of the internal state through the selected output shaping, so the value for a stream is available on the cycle after its last beat is accepted. The control word should stay constant while a stream is in progress.

Top module: `crcx_engine`

## Requirements
- R1: After synchronous reset the internal register is zero, `in_ready` is 1, and with a control word of zero `result` reads 0.
- R2: Mode field ctrl[3:0] uses MSB-first, non-reflected CRC arithmetic. Code 0 gives polynomial 0x8005 and code 1 gives 0x1021, both on a 16-bit register. Code 2 gives 0x04C11DB7 and code 3 gives 0x1EDC6F41, both on a 32-bit register. In the 16-bit modes `result[31:16]` is 0.
- R3: Lane field ctrl[5:4] reorders the beat before anything else. Output byte lane k (lane 3 is the most significant) takes input lane k XOR code. Code 0 gives B3,B2,B1,B0, code 1 gives B2,B3,B0,B1, code 2 gives B1,B0,B3,B2, and code 3 gives B0,B1,B2,B3.
- R4: Width bit ctrl[12] selects the item size. With 0, the item is the low 16 bits of the reordered beat and the upper half is ignored. With 1, the item is all 32 bits.
- R5: Input reflect bit ctrl[7] reverses the bit order of the item within its own width (16 or 32 bits). This happens after reordering and before the update.
- R6: Output reflect bit ctrl[8] reverses `result` within the width of the selected algorithm (16 bits for codes 0, 1 and 8; 32 bits for codes 2 and 3).
- R7: Complement bit ctrl[9] inverts `result` within the algorithm width. Reflection and inversion never touch bits above that width.
- R8: A restart loads the register according to ctrl[14:13], masked to the algorithm width. Code 0 loads the seed word, code 2 loads zeros and code 3 loads ones. Code 1 leaves the register unchanged.
- R9: Mode code 8 adds each 16-bit half-word of the item (both halves when ctrl[12]=1) into a 16-bit accumulator with end-around carry. Output complement applies only when ctrl[9] is set.
- R10: Any other mode code is reserved. An accepted beat leaves the register unchanged, a restart uses the full 32-bit width, and `result` shows the raw 32-bit register.
- R11: `in_ready` is 0 in any cycle where `restart` is 1. A beat offered in that cycle is not consumed. In every other cycle `in_ready` is 1.
- R12: Each accepted beat updates the register at the next clock edge. Beats may arrive back to back. Cycles with `in_valid` low leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 32 | Algorithm, shaping and start-value selection |
| seed_word | input | 32 | Start value used when the init field is 0 |
| restart | input | 1 | Load the start value on this clock edge |
| in_valid | input | 1 | Beat on `in_data` is offered |
| in_ready | output | 1 | Engine accepts the offered beat |
| in_data | input | 32 | Data beat |
| result | output | 32 | Shaped running CRC or checksum |

## Verification
A corrupted register bit shows at `result` one cycle after the beat that caused it, and every later beat carries the error forward through the feedback. So a comparison after each beat pins the fault to the exact beat. A wrong lane, reflection or width choice changes the value at once for items whose halves or bytes differ, which is why the directed cases use asymmetric single-bit patterns. Hold faults in reserved and idle cycles appear as a changed `result` on the following cycle.

// File: rtl/crcx_pkg.sv
package crcx_pkg;

    localparam int WORD_W  = 32;
    localparam int HALF_W  = WORD_W / 2;
    localparam int LANES   = WORD_W / 8;
    localparam int LANE_SW = $clog2(LANES);

    typedef enum logic [1:0] {
        KIND_CRC16 = 2'd0,
        KIND_CRC32 = 2'd1,
        KIND_SUM   = 2'd2,
        KIND_NONE  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        START_SEED  = 2'd0,
        START_RSVD  = 2'd1,
        START_ZERO  = 2'd2,
        START_ONES  = 2'd3
    } start_e;

    typedef struct packed {
        start_e             start;
        logic               wide;
        logic               cpl;
        logic               oref;
        logic               iref;
        logic [LANE_SW-1:0] lanes;
        logic [3:0]         mode;
    } ctrl_t;

    function automatic ctrl_t ctrl_decode(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.mode  = w[3:0];
        c.lanes = w[5:4];
        c.iref  = w[7];
        c.oref  = w[8];
        c.cpl   = w[9];
        c.wide  = w[12];
        c.start = start_e'(w[14:13]);
        return c;
    endfunction

    function automatic kind_e kind_of(input logic [3:0] mode);
        case (mode)
            4'd0, 4'd1: return KIND_CRC16;
            4'd2, 4'd3: return KIND_CRC32;
            4'd8:       return KIND_SUM;
            default:    return KIND_NONE;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] poly_of(input logic [3:0] mode);
        case (mode)
            4'd0:    return 32'h0000_8005;
            4'd1:    return 32'h0000_1021;
            4'd2:    return 32'h04C1_1DB7;
            4'd3:    return 32'h1EDC_6F41;
            default: return '0;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] width_mask(input kind_e k);
        if (k == KIND_CRC32 || k == KIND_NONE)
            return '1;
        return {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    endfunction

    function automatic logic [WORD_W-1:0] reflect(input logic [WORD_W-1:0] v,
                                                  input logic full);
        logic [WORD_W-1:0] r;
        r = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (full)
                r[i] = v[WORD_W-1-i];
            else if (i < HALF_W)
                r[i] = v[HALF_W-1-i];
        end
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] crc_feed(input logic [WORD_W-1:0] st,
                                                   input logic [WORD_W-1:0] item,
                                                   input logic item_full,
                                                   input logic [WORD_W-1:0] poly,
                                                   input logic reg_full);
        logic [WORD_W-1:0] s;
        logic [WORD_W-1:0] it;
        logic              fb;
        s  = st;
        it = item_full ? item : {item[HALF_W-1:0], {HALF_W{1'b0}}};
        for (int i = 0; i < WORD_W; i++) begin
            if (item_full || i < HALF_W) begin
                fb = (reg_full ? s[WORD_W-1] : s[HALF_W-1]) ^ it[WORD_W-1-i];
                s  = s << 1;
                if (fb)
                    s = s ^ poly;
                if (!reg_full)
                    s[WORD_W-1:HALF_W] = '0;
            end
        end
        return s;
    endfunction

    function automatic logic [HALF_W-1:0] oc_add(input logic [HALF_W-1:0] a,
                                                 input logic [HALF_W-1:0] b);
        logic [HALF_W:0] t;
        t = {1'b0, a} + {1'b0, b};
        return t[HALF_W-1:0] + {{(HALF_W-1){1'b0}}, t[HALF_W]};
    endfunction

endpackage

// File: rtl/crcx_shaper.sv
module crcx_shaper
    import crcx_pkg::*;
(
    input  logic [WORD_W-1:0]  raw,
    input  logic [LANE_SW-1:0] lanes,
    input  logic               wide,
    input  logic               iref,
    output logic [WORD_W-1:0]  item
);
    logic [WORD_W-1:0] ordered;
    logic [WORD_W-1:0] sized;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_SW-1:0] src;
        assign src = LANE_SW'(k) ^ lanes;
        assign ordered[8*k +: 8] = raw[{src, 3'b000} +: 8];
    end

    always_comb begin
        sized = wide ? ordered : {{HALF_W{1'b0}}, ordered[HALF_W-1:0]};
        item  = iref ? reflect(sized, wide) : sized;
    end
endmodule

// File: rtl/crcx_state.sv
module crcx_state
    import crcx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              take,
    input  ctrl_t             ctrl,
    input  kind_e             kind,
    input  logic [WORD_W-1:0] seed,
    input  logic [WORD_W-1:0] item,
    output logic [WORD_W-1:0] state_q
);
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] start_v;
    logic              start_ok;
    logic [WORD_W-1:0] next_v;
    logic [HALF_W-1:0] sum_v;

    always_comb begin
        mask     = width_mask(kind);
        start_ok = 1'b1;
        case (ctrl.start)
            START_SEED: start_v = seed & mask;
            START_ZERO: start_v = '0;
            START_ONES: start_v = mask;
            default: begin
                start_v  = state_q;
                start_ok = 1'b0;
            end
        endcase
    end

    always_comb begin
        sum_v = oc_add(state_q[HALF_W-1:0], item[HALF_W-1:0]);
        if (ctrl.wide)
            sum_v = oc_add(sum_v, item[WORD_W-1:HALF_W]);
        case (kind)
            KIND_CRC16: next_v = crc_feed(state_q, item, ctrl.wide, poly_of(ctrl.mode), 1'b0);
            KIND_CRC32: next_v = crc_feed(state_q, item, ctrl.wide, poly_of(ctrl.mode), 1'b1);
            KIND_SUM:   next_v = {{HALF_W{1'b0}}, sum_v};
            default:    next_v = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= '0;
        else if (restart) begin
            if (start_ok)
                state_q <= start_v;
        end else if (take)
            state_q <= next_v;
    end
endmodule

// File: rtl/crcx_out.sv
module crcx_out
    import crcx_pkg::*;
(
    input  logic [WORD_W-1:0] state_q,
    input  ctrl_t             ctrl,
    input  kind_e             kind,
    output logic [WORD_W-1:0] result
);
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] v;

    always_comb begin
        mask = width_mask(kind);
        v    = state_q & mask;
        if (kind == KIND_NONE)
            result = state_q;
        else begin
            if (ctrl.oref)
                v = reflect(v, kind == KIND_CRC32);
            if (ctrl.cpl)
                v = v ^ mask;
            result = v;
        end
    end
endmodule

// File: rtl/crcx_engine.sv
module crcx_engine
    import crcx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] ctrl_word,
    input  logic [31:0] seed_word,
    input  logic        restart,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_data,
    output logic [31:0] result
);
    ctrl_t             ctrl;
    kind_e             kind;
    logic [WORD_W-1:0] item;
    logic [WORD_W-1:0] state_q;
    logic              ctrl_unused;

    assign ctrl        = ctrl_decode(ctrl_word);
    assign kind        = kind_of(ctrl.mode);
    assign ctrl_unused = ^{ctrl_word[31:15], ctrl_word[11:10], ctrl_word[6]};
    assign in_ready    = !restart;

    crcx_shaper u_shape (
        .raw   (in_data),
        .lanes (ctrl.lanes),
        .wide  (ctrl.wide),
        .iref  (ctrl.iref),
        .item  (item)
    );

    crcx_state u_state (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .take    (in_valid && in_ready),
        .ctrl    (ctrl),
        .kind    (kind),
        .seed    (seed_word),
        .item    (item),
        .state_q (state_q)
    );

    crcx_out u_out (
        .state_q (state_q),
        .ctrl    (ctrl),
        .kind    (kind),
        .result  (result)
    );
endmodule

// File: rtl/crcx_engine_chk.sv
module crcx_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] ctrl_word,
    input logic        restart,
    input logic        in_valid,
    input logic        in_ready,
    input logic [31:0] result,
    input logic [31:0] state_q
);
    logic narrow;
    logic reserved;
    assign narrow   = ctrl_word[3:0] inside {4'd0, 4'd1, 4'd8};
    assign reserved = !(ctrl_word[3:0] inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd8});

    assert_restart_blocks_R11: assert property (@(posedge clk) disable iff (rst)
        restart |-> !in_ready);

    assert_ready_otherwise_R11: assert property (@(posedge clk) disable iff (rst)
        !restart |-> in_ready);

    assert_zero_start_R8: assert property (@(posedge clk) disable iff (rst)
        (restart && ctrl_word[14:13] == 2'd2) |=> state_q == 32'h0);

    assert_rsvd_start_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (restart && ctrl_word[14:13] == 2'd1) |=> $stable(state_q));

    assert_rsvd_mode_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!restart && in_valid && reserved) |=> $stable(state_q));

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (!restart && !in_valid) |=> $stable(state_q));

    assert_narrow_upper_R2: assert property (@(posedge clk) disable iff (rst)
        narrow |-> result[31:16] == 16'h0);
endmodule

bind crcx_engine crcx_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl_word (ctrl_word),
    .restart   (restart),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .result    (result),
    .state_q   (state_q)
);

// File: tb/sim_crcx_engine.sv
`timescale 1ns/1ps
module sim_crcx_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ctrl_word = '0;
    logic [31:0] seed_word = '0;
    logic        restart = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic [31:0] result;

    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;
    logic [31:0] m_st = '0;

    always #10 clk = ~clk;

    crcx_engine u0 (
        .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .seed_word(seed_word),
        .restart(restart), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .result(result)
    );

    function automatic logic [31:0] mk(input logic [3:0] mode, input logic [1:0] lanes,
                                       input logic iref, input logic oref, input logic cpl,
                                       input logic wide, input logic [1:0] init);
        return {17'b0, init, wide, 2'b0, cpl, oref, iref, 1'b0, lanes, mode};
    endfunction

    // 0 crc16, 1 crc32, 2 sum, 3 reserved
    function automatic int m_kind(input logic [3:0] mode);
        if (mode == 0 || mode == 1) return 0;
        if (mode == 2 || mode == 3) return 1;
        if (mode == 8) return 2;
        return 3;
    endfunction

    function automatic logic [31:0] m_mask(input logic [3:0] mode);
        int k = m_kind(mode);
        return (k == 1 || k == 3) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction

    function automatic logic [31:0] m_rev(input logic [31:0] v, input int n);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) r[n-1-i] = v[i];
        return r;
    endfunction

    function automatic logic [31:0] m_item(input logic [31:0] d, input logic [31:0] c);
        logic [31:0] w;
        case (c[5:4])
            2'd0: w = d;
            2'd1: w = {d[23:16], d[31:24], d[7:0], d[15:8]};
            2'd2: w = {d[15:0], d[31:16]};
            default: w = {d[7:0], d[15:8], d[23:16], d[31:24]};
        endcase
        if (!c[12]) w = {16'h0, w[15:0]};
        if (c[7]) w = m_rev(w, c[12] ? 32 : 16);
        return w;
    endfunction

    function automatic logic [15:0] m_add(input logic [15:0] a, input logic [15:0] b);
        logic [31:0] t = {16'h0, a} + {16'h0, b};
        while (t[31:16] != 0) t = {16'h0, t[15:0]} + {16'h0, t[31:16]};
        return t[15:0];
    endfunction

    function automatic logic [31:0] m_update(input logic [31:0] st, input logic [31:0] d,
                                             input logic [31:0] c);
        logic [31:0] it = m_item(d, c);
        int          nb = c[12] ? 32 : 16;
        int          k  = m_kind(c[3:0]);
        logic [15:0] r16 = st[15:0];
        logic [31:0] r32 = st;
        logic [31:0] p;
        case (c[3:0])
            4'd0: p = 32'h8005;
            4'd1: p = 32'h1021;
            4'd2: p = 32'h04C11DB7;
            default: p = 32'h1EDC6F41;
        endcase
        if (k == 0) begin
            for (int b = nb - 1; b >= 0; b--)
                r16 = {r16[14:0], 1'b0} ^ (((r16[15] ^ it[b]) != 0) ? p[15:0] : 16'h0);
            return {16'h0, r16};
        end
        if (k == 1) begin
            for (int b = nb - 1; b >= 0; b--)
                r32 = {r32[30:0], 1'b0} ^ (((r32[31] ^ it[b]) != 0) ? p : 32'h0);
            return r32;
        end
        if (k == 2) begin
            r16 = m_add(st[15:0], it[15:0]);
            if (c[12]) r16 = m_add(r16, it[31:16]);
            return {16'h0, r16};
        end
        return st;
    endfunction

    function automatic logic [31:0] m_result(input logic [31:0] st, input logic [31:0] c);
        int          k = m_kind(c[3:0]);
        logic [31:0] v;
        if (k == 3) return st;
        v = st & m_mask(c[3:0]);
        if (c[8]) v = m_rev(v, k == 1 ? 32 : 16);
        if (c[9]) v = v ^ m_mask(c[3:0]);
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic set_ctrl(input logic [31:0] c);
        @(negedge clk);
        ctrl_word = c;
    endtask

    task automatic do_restart();
        @(negedge clk);
        restart = 1'b1;
        #1 check("R11 ready low on restart", {31'b0, in_ready}, 32'h0);
        @(negedge clk);
        restart = 1'b0;
        case (ctrl_word[14:13])
            2'd0: m_st = seed_word & m_mask(ctrl_word[3:0]);
            2'd2: m_st = '0;
            2'd3: m_st = m_mask(ctrl_word[3:0]);
            default: m_st = m_st;
        endcase
    endtask

    task automatic beat(input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
        m_st = m_update(m_st, d, ctrl_word);
        #1;
    endtask

    task automatic start(input logic [31:0] c);
        set_ctrl(c);
        do_restart();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] c;
        logic [31:0] keep;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset result", result, 32'h0);
        check("R1 ready after reset", {31'b0, in_ready}, 32'h1);

        // R2 polynomials, single-one item from zero
        start(mk(4'd0, 2'd0, 0, 0, 0, 0, 2'd2)); beat(32'h0000_0001);
        check("R2 poly 8005", result, 32'h0000_8005);
        start(mk(4'd1, 2'd0, 0, 0, 0, 0, 2'd2)); beat(32'hFFFF_0001);
        check("R2 poly 1021 upper zero", result, 32'h0000_1021);
        start(mk(4'd2, 2'd0, 0, 0, 0, 1, 2'd2)); beat(32'h0000_0001);
        check("R2 poly 04C11DB7", result, 32'h04C1_1DB7);
        start(mk(4'd3, 2'd0, 0, 0, 0, 1, 2'd2)); beat(32'h0000_0001);
        check("R2 poly 1EDC6F41", result, 32'h1EDC_6F41);

        // R3 lane reordering
        start(mk(4'd0, 2'd1, 0, 0, 0, 0, 2'd2)); beat(32'h0000_0100);
        check("R3 lanes code 1", result, 32'h0000_8005);
        start(mk(4'd0, 2'd2, 0, 0, 0, 0, 2'd2)); beat(32'h0001_0000);
        check("R3 lanes code 2", result, 32'h0000_8005);
        start(mk(4'd0, 2'd3, 0, 0, 0, 0, 2'd2)); beat(32'h0100_0000);
        check("R3 lanes code 3", result, 32'h0000_8005);

        // R4 item size, seen through the checksum
        start(mk(4'd8, 2'd0, 0, 0, 0, 1, 2'd2)); beat(32'h0002_0003);
        check("R4 wide item", result, 32'h0000_0005);
        start(mk(4'd8, 2'd0, 0, 0, 0, 0, 2'd2)); beat(32'h0002_0003);
        check("R4 narrow ignores upper half", result, 32'h0000_0003);

        // R5 input reflect
        start(mk(4'd0, 2'd0, 1, 0, 0, 0, 2'd2)); beat(32'h0000_8000);
        check("R5 reflect 16", result, 32'h0000_8005);
        start(mk(4'd2, 2'd0, 1, 0, 0, 1, 2'd2)); beat(32'h8000_0000);
        check("R5 reflect 32", result, 32'h04C1_1DB7);

        // R6 output reflect, R7 complement
        start(mk(4'd0, 2'd0, 0, 1, 0, 0, 2'd2)); beat(32'h0000_0001);
        check("R6 out reflect 16", result, 32'h0000_A001);
        start(mk(4'd0, 2'd0, 0, 0, 1, 0, 2'd2)); beat(32'h0000_0001);
        check("R7 complement 16", result, 32'h0000_7FFA);
        start(mk(4'd2, 2'd0, 0, 0, 1, 1, 2'd2)); beat(32'h0000_0001);
        check("R7 complement 32", result, 32'hFB3E_E248);

        // R8 start values
        seed_word = 32'h1234_5678;
        start(mk(4'd1, 2'd0, 0, 0, 0, 0, 2'd0));
        check("R8 seed masked 16", result, 32'h0000_5678);
        start(mk(4'd2, 2'd0, 0, 0, 0, 0, 2'd0));
        check("R8 seed 32", result, 32'h1234_5678);
        start(mk(4'd0, 2'd0, 0, 0, 0, 0, 2'd3));
        check("R8 ones 16", result, 32'h0000_FFFF);
        start(mk(4'd0, 2'd0, 0, 0, 0, 0, 2'd1));
        check("R8 reserved start holds", result, 32'h0000_FFFF);
        start(mk(4'd0, 2'd0, 0, 0, 0, 0, 2'd2));
        check("R8 zeros", result, 32'h0);

        // R9 checksum end-around carry
        start(mk(4'd8, 2'd0, 0, 0, 0, 1, 2'd2)); beat(32'hFFFF_0001);
        check("R9 end-around carry", result, 32'h0000_0001);
        set_ctrl(mk(4'd8, 2'd0, 0, 0, 1, 1, 2'd2)); #1;
        check("R9 complemented sum", result, 32'h0000_FFFE);

        // R10 reserved mode
        start(mk(4'd5, 2'd0, 0, 1, 1, 1, 2'd3));
        check("R10 reserved start full width", result, 32'hFFFF_FFFF);
        beat(32'h1234_5678);
        check("R10 reserved mode holds", result, 32'hFFFF_FFFF);

        // R11 restart wins over an offered beat
        start(mk(4'd0, 2'd0, 0, 0, 0, 0, 2'd2)); beat(32'h0000_0001);
        @(negedge clk);
        restart = 1'b1; in_valid = 1'b1; in_data = 32'h0000_0001;
        @(negedge clk);
        restart = 1'b0; in_valid = 1'b0; m_st = '0; #1;
        check("R11 beat not consumed", result, 32'h0);

        // R12 back-to-back beats and idle cycles
        start(mk(4'd1, 2'd0, 0, 0, 0, 1, 2'd3));
        @(negedge clk); in_valid = 1'b1; in_data = 32'hDEAD_BEEF;
        @(negedge clk); in_data = 32'h0BAD_F00D;
        m_st = m_update(m_st, 32'hDEAD_BEEF, ctrl_word);
        @(negedge clk); in_valid = 1'b0;
        m_st = m_update(m_st, 32'h0BAD_F00D, ctrl_word); #1;
        check("R12 back to back", result, m_result(m_st, ctrl_word));
        keep = result;
        repeat (3) @(negedge clk);
        #1 check("R12 idle holds", result, keep);

        // Random sessions
        for (int s = 0; s < 60; s++) begin
            logic [3:0] md;
            case ($urandom % 6)
                0: md = 4'd0; 1: md = 4'd1; 2: md = 4'd2;
                3: md = 4'd3; 4: md = 4'd8; default: md = 4'd11;
            endcase
            seed_word = $urandom;
            c = mk(md, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), 2'($urandom));
            start(c);
            for (int b = 0; b < 1 + int'($urandom % 6); b++) begin
                beat($urandom);
                check("R12 random stream", result, m_result(m_st, ctrl_word));
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule